// File: doc/BRIEF.md
# Speculative Load Poison Tag and Verify Unit

This block sits beside the register file of a core that runs code produced by a translating compiler. That compiler moves loads above branches and above stores. When such a hoisted load arrives, the unit decides whether it may reach memory. An address inside the I/O window, or a fault reported by address translation, stops the request. The block does not signal such a failure straight away. It records it as a poison tag on the load's destination register.

At the point where the load would have sat in program order, the compiled code issues a check on that register. If the register carries poison, the unit raises a one-cycle trap so that the translator can re-execute the load in order. The unit also has a separate verify port. It compares the speculatively loaded value with a fresh reload from the same address. A difference shows that a store aliased the load, and the unit traps with a distinct cause so that recovery code can run.

Top module: `spec_load_guard`

## Requirements
- R1: A speculative load whose address lies in the inclusive window IO_BASE..IO_LIMIT, or that arrives with `ld_fault` high, drives no memory request: `mem_req` stays low in that cycle. Every other speculative load drives `mem_req` high in the same cycle, with `mem_addr` equal to `ld_addr`.
- R2: A load held back by the I/O window sets the poison bit of `ld_dst`. The bit reads 1 on `poison[ld_dst]` from the cycle after the load onward.
- R3: A load that arrives with `ld_fault` high sets the poison bit of its destination in the same way. The load raises no trap by itself.
- R4: A speculative load that does reach memory clears the poison bit of its destination from the next cycle onward.
- R5: A non-speculative write (`wr_valid`) clears the poison bit of `wr_reg` from the next cycle onward. When a speculative load targets the same register in the same cycle, the load's outcome decides the bit.
- R6: A check (`chk_valid`) on a register whose poison bit is set raises `trap` for exactly one cycle, in the cycle after the check, with `trap_cause` = 2'b01. A check on a clean register raises nothing. A check leaves the poison bits unchanged.
- R7: A verify (`vfy_valid`) with equal speculative and reloaded values raises nothing. Unequal values raise `trap` for one cycle, in the cycle after the verify, with `trap_cause` = 2'b10.
- R8: When a trapping check and a mismatching verify fall in the same cycle, the trap reports `trap_cause` = 2'b01.
- R9: `trap` rises only in the cycle after a trapping check or a mismatching verify. A poisoned register that is overwritten or never checked causes no trap. `trap_cause` reads 2'b00 whenever `trap` is low.
- R10: While `rst_n` is low, every poison bit reads 0, `trap` is low and `trap_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A speculative load is presented this cycle |
| ld_dst | input | 6 | Destination register of the speculative load |
| ld_addr | input | 32 | Address of the speculative load |
| ld_fault | input | 1 | Address translation reports a fault for this load |
| mem_req | output | 1 | Load request strobe to memory |
| mem_addr | output | 32 | Address of the memory request |
| wr_valid | input | 1 | A non-speculative register write occurs this cycle |
| wr_reg | input | 6 | Register written non-speculatively |
| chk_valid | input | 1 | In-order check of a register this cycle |
| chk_reg | input | 6 | Register being checked |
| vfy_valid | input | 1 | A load-verify compare occurs this cycle |
| vfy_spec_data | input | 32 | Value obtained by the speculative load |
| vfy_reload_data | input | 32 | Value obtained by the in-order reload |
| poison | output | 64 | One poison tag per register |
| trap | output | 1 | One-cycle trap request to the translator |
| trap_cause | output | 2 | 00 none, 01 deferred fault, 10 verify mismatch |

## Verification
The memory strobe and its address are combinational, so the bench samples them one nanosecond after it drives the load, inside the same cycle. Poison tags and the trap both come from one register stage. Their effects are due in the cycle after the stimulus, and the bench compares them at the falling edge that follows the next rising edge. A behavioural model in the bench advances on each rising edge and predicts the whole poison vector, the trap and the cause for each cycle. Directed cases cover the window boundaries, same-cycle write/load collisions and the trap-priority case; a long random phase on a few registers adds further collisions.

// File: rtl/slg_pkg.sv
`timescale 1ns/1ps
package slg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_DEFERRED = 2'b01,
    CAUSE_MISMATCH = 2'b10
  } trap_cause_e;
endpackage

// File: rtl/slg_range_decode.sv
`timescale 1ns/1ps
// Marks addresses that fall inside the inclusive I/O window.
module slg_range_decode #(
  parameter int          AW       = 32,
  parameter logic [31:0] IO_BASE  = 32'hF000_0000,
  parameter logic [31:0] IO_LIMIT = 32'hFFFE_FFFF
) (
  input  logic [AW-1:0] addr,
  output logic          in_io
);
  localparam logic [AW-1:0] LO = AW'(IO_BASE);
  localparam logic [AW-1:0] HI = AW'(IO_LIMIT);

  always_comb begin
    in_io = (addr >= LO) && (addr <= HI);
  end
endmodule

// File: rtl/slg_poison_array.sv
`timescale 1ns/1ps
// One tag flop per register, each with its own written-out enable.
module slg_poison_array #(
  parameter int NREG = 64,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [IW-1:0]   ld_idx,
  input  logic            ld_bad,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [IW-1:0]   rd_idx,
  output logic [NREG-1:0] tags,
  output logic            rd_tag
);
  for (genvar g = 0; g < NREG; g++) begin : g_tag
    logic set_hit, clr_hit, tag_en, tag_d, tag_q;

    always_comb begin
      set_hit = ld_en && (ld_idx == IW'(g));
      clr_hit = wr_en && (wr_idx == IW'(g));
      tag_en  = set_hit || clr_hit;
      // a speculative load to the same register decides over a plain write
      tag_d   = set_hit ? ld_bad : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q <= 1'b0;
      else if (tag_en) tag_q <= tag_d;
    end

    assign tags[g] = tag_q;
  end

  always_comb begin
    rd_tag = tags[rd_idx];
  end
endmodule

// File: rtl/slg_verify_cmp.sv
`timescale 1ns/1ps
// Compares the speculatively loaded word against the in-order reload.
module slg_verify_cmp #(
  parameter int DW = 32
) (
  input  logic          vfy_en,
  input  logic [DW-1:0] spec_word,
  input  logic [DW-1:0] reload_word,
  output logic          differs
);
  always_comb begin
    differs = vfy_en && (spec_word != reload_word);
  end
endmodule

// File: rtl/slg_trap_gen.sv
`timescale 1ns/1ps
// Registers a single-cycle trap; a deferred fault outranks a mismatch.
module slg_trap_gen
  import slg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        defer_hit,
  input  logic        mismatch,
  output logic        trap_q,
  output trap_cause_e cause_q
);
  logic        trap_d;
  trap_cause_e cause_d;

  always_comb begin
    trap_d  = defer_hit || mismatch;
    cause_d = CAUSE_NONE;
    if (defer_hit)     cause_d = CAUSE_DEFERRED;
    else if (mismatch) cause_d = CAUSE_MISMATCH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/spec_load_guard.sv
`timescale 1ns/1ps
module spec_load_guard #(
  parameter int          NREG     = 64,
  parameter int          DW       = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] IO_BASE  = 32'hF000_0000,
  parameter logic [31:0] IO_LIMIT = 32'hFFFE_FFFF,
  localparam int         IW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  input  logic [IW-1:0]   ld_dst,
  input  logic [AW-1:0]   ld_addr,
  input  logic            ld_fault,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            wr_valid,
  input  logic [IW-1:0]   wr_reg,
  input  logic            chk_valid,
  input  logic [IW-1:0]   chk_reg,
  input  logic            vfy_valid,
  input  logic [DW-1:0]   vfy_spec_data,
  input  logic [DW-1:0]   vfy_reload_data,
  output logic [NREG-1:0] poison,
  output logic            trap,
  output logic [1:0]      trap_cause
);
  import slg_pkg::*;

  logic        io_hit;
  logic        load_bad;
  logic        chk_tag;
  logic        defer_hit;
  logic        vfy_diff;
  trap_cause_e cause_q;

  slg_range_decode #(
    .AW(AW), .IO_BASE(IO_BASE), .IO_LIMIT(IO_LIMIT)
  ) u_range (
    .addr (ld_addr),
    .in_io(io_hit)
  );

  always_comb begin
    load_bad  = io_hit || ld_fault;
    mem_req   = ld_valid && !load_bad;
    mem_addr  = ld_addr;
    defer_hit = chk_valid && chk_tag;
  end

  slg_poison_array #(.NREG(NREG)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_en (ld_valid),
    .ld_idx(ld_dst),
    .ld_bad(load_bad),
    .wr_en (wr_valid),
    .wr_idx(wr_reg),
    .rd_idx(chk_reg),
    .tags  (poison),
    .rd_tag(chk_tag)
  );

  slg_verify_cmp #(.DW(DW)) u_cmp (
    .vfy_en     (vfy_valid),
    .spec_word  (vfy_spec_data),
    .reload_word(vfy_reload_data),
    .differs    (vfy_diff)
  );

  slg_trap_gen u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .defer_hit(defer_hit),
    .mismatch (vfy_diff),
    .trap_q   (trap),
    .cause_q  (cause_q)
  );

  assign trap_cause = cause_q;
endmodule

// File: rtl/slg_checker.sv
`timescale 1ns/1ps
module slg_checker #(
  parameter int          NREG     = 64,
  parameter int          DW       = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] IO_BASE  = 32'hF000_0000,
  parameter logic [31:0] IO_LIMIT = 32'hFFFE_FFFF,
  localparam int         IW       = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_valid,
  input logic [IW-1:0]   ld_dst,
  input logic [AW-1:0]   ld_addr,
  input logic            ld_fault,
  input logic            mem_req,
  input logic            wr_valid,
  input logic [IW-1:0]   wr_reg,
  input logic            chk_valid,
  input logic [IW-1:0]   chk_reg,
  input logic            vfy_valid,
  input logic [DW-1:0]   vfy_spec_data,
  input logic [DW-1:0]   vfy_reload_data,
  input logic [NREG-1:0] poison,
  input logic            trap,
  input logic [1:0]      trap_cause
);
  logic addr_io;
  assign addr_io = (ld_addr >= AW'(IO_BASE)) && (ld_addr <= AW'(IO_LIMIT));

  assert_io_quashed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (addr_io || ld_fault)) |-> !mem_req);

  assert_io_poisons_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && addr_io) |=> poison[$past(ld_dst)]);

  assert_fault_poisons_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_fault) |=> poison[$past(ld_dst)]);

  assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !(ld_valid && ld_dst == wr_reg)) |=> !poison[$past(wr_reg)]);

  assert_check_traps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && poison[chk_reg]) |=> (trap && trap_cause == 2'b01));

  assert_verify_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_valid && vfy_spec_data == vfy_reload_data &&
     !(chk_valid && poison[chk_reg])) |=> !trap);

  assert_no_spurious_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_valid && !vfy_valid) |=> !trap);

  assert_cause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> trap_cause == 2'b00);
endmodule

bind spec_load_guard slg_checker #(
  .NREG(NREG), .DW(DW), .AW(AW), .IO_BASE(IO_BASE), .IO_LIMIT(IO_LIMIT)
) u_slg_checker (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_dst(ld_dst),
  .ld_addr(ld_addr), .ld_fault(ld_fault), .mem_req(mem_req),
  .wr_valid(wr_valid), .wr_reg(wr_reg), .chk_valid(chk_valid),
  .chk_reg(chk_reg), .vfy_valid(vfy_valid), .vfy_spec_data(vfy_spec_data),
  .vfy_reload_data(vfy_reload_data), .poison(poison), .trap(trap),
  .trap_cause(trap_cause)
);

// File: tb/spec_load_guard_tb_top.sv
`timescale 1ns/1ps
module spec_load_guard_tb_top;
  localparam int          NREG = 64;
  localparam logic [31:0] IOB  = 32'hF000_0000;
  localparam logic [31:0] IOL  = 32'hFFFE_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, ld_fault, wr_valid, chk_valid, vfy_valid;
  logic [5:0]  ld_dst, wr_reg, chk_reg;
  logic [31:0] ld_addr, vfy_spec_data, vfy_reload_data;
  logic        mem_req, trap;
  logic [31:0] mem_addr;
  logic [63:0] poison;
  logic [1:0]  trap_cause;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  logic [63:0] m_poison;
  logic        m_trap;
  logic [1:0]  m_cause;

  always #2.5 clk = ~clk;

  spec_load_guard #(.NREG(NREG), .IO_BASE(IOB), .IO_LIMIT(IOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_dst(ld_dst),
    .ld_addr(ld_addr), .ld_fault(ld_fault), .mem_req(mem_req),
    .mem_addr(mem_addr), .wr_valid(wr_valid), .wr_reg(wr_reg),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .vfy_valid(vfy_valid),
    .vfy_spec_data(vfy_spec_data), .vfy_reload_data(vfy_reload_data),
    .poison(poison), .trap(trap), .trap_cause(trap_cause)
  );

  function automatic bit in_window(input logic [31:0] a);
    return (a >= IOB) && (a <= IOL);
  endfunction

  task automatic expect_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic clear_inputs();
    ld_valid = 0; ld_fault = 0; wr_valid = 0; chk_valid = 0; vfy_valid = 0;
    ld_dst = 0; wr_reg = 0; chk_reg = 0; ld_addr = 0;
    vfy_spec_data = 0; vfy_reload_data = 0;
  endtask

  // Inputs are set by the caller just after a falling edge.
  task automatic cyc(input string req);
    bit exp_req, hit, mis;
    #1;
    exp_req = ld_valid && !in_window(ld_addr) && !ld_fault;
    expect_eq(req, "mem_req", 64'(mem_req), 64'(exp_req));
    if (exp_req) expect_eq(req, "mem_addr", 64'(mem_addr), 64'(ld_addr));
    @(posedge clk);
    hit = chk_valid && m_poison[chk_reg];
    mis = vfy_valid && (vfy_spec_data != vfy_reload_data);
    m_trap  = hit || mis;
    m_cause = hit ? 2'b01 : (mis ? 2'b10 : 2'b00);
    if (wr_valid) m_poison[wr_reg] = 1'b0;
    if (ld_valid) m_poison[ld_dst] = in_window(ld_addr) || ld_fault;
    @(negedge clk);
    expect_eq(req, "poison", poison, m_poison);
    expect_eq(req, "trap", 64'(trap), 64'(m_trap));
    expect_eq(req, "trap_cause", 64'(trap_cause), 64'(m_cause));
    clear_inputs();
  endtask

  task automatic spec_ld(input logic [5:0] d, input logic [31:0] a, input bit f);
    ld_valid = 1; ld_dst = d; ld_addr = a; ld_fault = f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    report();
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    m_poison = '0; m_trap = 0; m_cause = 0;
    #1;
    // R10: reset state
    expect_eq("R10", "poison", poison, 64'd0);
    expect_eq("R10", "trap", 64'(trap), 64'd0);
    expect_eq("R10", "trap_cause", 64'(trap_cause), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R10");

    // R1: window boundaries and ordinary loads
    spec_ld(6'd1, 32'h0000_1000, 0);  cyc("R1");
    spec_ld(6'd2, IOB - 32'd1, 0);    cyc("R1");
    spec_ld(6'd3, IOL + 32'd1, 0);    cyc("R1");
    // R2: quashed loads poison destination
    spec_ld(6'd4, IOB, 0);            cyc("R2");
    spec_ld(6'd5, IOL, 0);            cyc("R2");
    spec_ld(6'd63, 32'hF800_0000, 0); cyc("R2");
    // R3: faulting load poisons without trapping
    spec_ld(6'd6, 32'h0000_2000, 1);  cyc("R3");
    cyc("R3");
    // R4: clean load clears earlier poison
    spec_ld(6'd4, 32'h0000_3000, 0);  cyc("R4");
    // R5: write clears; load wins when both hit one register
    wr_valid = 1; wr_reg = 6'd5;      cyc("R5");
    spec_ld(6'd7, IOB, 0); wr_valid = 1; wr_reg = 6'd7; cyc("R5");
    wr_valid = 1; wr_reg = 6'd63; chk_valid = 0; cyc("R5");
    // R6: checks of poisoned and clean registers
    chk_valid = 1; chk_reg = 6'd6;    cyc("R6");
    cyc("R6");
    chk_valid = 1; chk_reg = 6'd6;    cyc("R6");
    chk_valid = 1; chk_reg = 6'd1;    cyc("R6");
    // R9: poison cleared by write before its check -> no trap
    wr_valid = 1; wr_reg = 6'd6;      cyc("R9");
    chk_valid = 1; chk_reg = 6'd6;    cyc("R9");
    // R7: verify match and mismatch
    vfy_valid = 1; vfy_spec_data = 32'hCAFE_0001; vfy_reload_data = 32'hCAFE_0001; cyc("R7");
    vfy_valid = 1; vfy_spec_data = 32'hCAFE_0001; vfy_reload_data = 32'hCAFE_0003; cyc("R7");
    cyc("R7");
    // R8: both in one cycle
    chk_valid = 1; chk_reg = 6'd7;
    vfy_valid = 1; vfy_spec_data = 32'h1; vfy_reload_data = 32'h2; cyc("R8");

    // R1..R9 random mix on a few registers for collisions
    for (int i = 0; i < 3000; i++) begin
      ld_valid  = ($urandom_range(0, 2) == 0);
      ld_dst    = 6'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0:       ld_addr = IOB + 32'($urandom_range(0, 3)) - 32'd2;
        1:       ld_addr = IOL + 32'($urandom_range(0, 3)) - 32'd2;
        default: ld_addr = $urandom;
      endcase
      ld_fault  = ($urandom_range(0, 5) == 0);
      wr_valid  = ($urandom_range(0, 3) == 0);
      wr_reg    = 6'($urandom_range(0, 7));
      chk_valid = ($urandom_range(0, 2) == 0);
      chk_reg   = 6'($urandom_range(0, 7));
      vfy_valid = ($urandom_range(0, 3) == 0);
      vfy_spec_data   = 32'($urandom_range(0, 3));
      vfy_reload_data = 32'($urandom_range(0, 3));
      cyc("RND");
    end
    report();
  end
endmodule